// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers the interrupt conditions of a multi-channel converter peripheral. It turns them into one registered interrupt request and one vector value that software reads. There are five status conditions: converter overflow, conversion-timing overflow, and three window-comparator outcomes (above, below, inside). There is also one result-ready condition per result slot. Each source has a pending flag, a set pulse and an enable bit. The vector names the highest-ranked source that is both pending and enabled. Its value is an even number, so an interrupt handler can add it straight to its program counter and land in a jump table.

Reading the vector has a side effect. If the winning source is a status condition, its flag is dropped. If the winner is a result-ready flag, the read leaves it alone: that flag falls only when its result slot is read or when software clears it directly. Writing the vector wipes every pending flag. A set pulse always beats a clear arriving in the same cycle, so no event is lost.

Top module: `ivg_top`

## Requirements
- R1: When no source is both pending and enabled, `vector_o` reads 0.
- R2: Otherwise `vector_o` equals 2*(k+1), where k is the rank of the best enabled pending source. The ranks, from highest priority down, are: overflow k=0, timing overflow k=1, window-above k=2, window-below k=3, window-inside k=4, and result slot s at k=5+s. Bit k of `src_en_i`, `src_set_i`, `src_clr_i` and `pend_o` belongs to the source of rank k.
- R3: A pending source whose enable bit is clear has no effect on `vector_o` or `irq_o`. Its pending flag is kept and shows again once it is enabled.
- R4: A vector read clears the flag of the winning source when that source is a status condition (k below 5).
- R5: A vector read whose winner is a result-ready flag clears nothing.
- R6: A pulse on `slot_rd_i[s]` clears the result-ready flag of slot s.
- R7: A pulse on `src_clr_i[k]` clears the flag of source k.
- R8: A vector write clears every pending flag.
- R9: When a set pulse and any clear event hit the same flag in one cycle, the flag ends up set.
- R10: `irq_o` is a register. After each clock edge it equals the OR of the pending flags ANDed with the enables that were applied before that edge. It therefore stays high while any other enabled flag remains pending after a clear.
- R11: After reset, all flags are clear, `irq_o` is 0 and `vector_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vec_rd_i | input | 1 | Vector read strobe (read-clear side effect) |
| vec_wr_i | input | 1 | Vector write strobe (clears all flags) |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| src_set_i | input | NUM_SRC | Per-source set pulses |
| src_clr_i | input | NUM_SRC | Per-source software clear pulses |
| slot_rd_i | input | NUM_SLOTS | Per-slot result-read strobes |
| irq_o | output | 1 | Registered interrupt request |
| vector_o | output | VEC_W | Vector value of the top enabled pending source |
| pend_o | output | NUM_SRC | Pending flags |

## Verification
The bench builds the block with NUM_SLOTS set to 4, which gives nine sources and a 5-bit vector. With that setting, both the lowest slot (vector 12) and the highest slot (vector 18) can be reached in a few cycles. Ties between the overflow flag and the slot-3 flag can then be raised and resolved by successive reads. The sequences mix read, write, slot-read and software-clear events with set pulses in the same cycle, and they change the enables while flags are pending.

// File: rtl/ivg_pkg.sv
`timescale 1ns/1ps
package ivg_pkg;

    // Number of status conditions ranked ahead of the result slots
    localparam int STAT_CNT = 5;

    typedef enum int unsigned {
        SRC_OVF = 0,   // converter overflow
        SRC_TOV = 1,   // conversion-timing overflow
        SRC_WHI = 2,   // window: above high threshold
        SRC_WLO = 3,   // window: below low threshold
        SRC_WIN = 4    // window: inside band
    } stat_src_e;

endpackage

// File: rtl/ivg_prio_pick.sv
`timescale 1ns/1ps
// Finds the lowest-index asserted request (index 0 ranks highest).
module ivg_prio_pick #(
    parameter int W  = 13,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vld_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ivg_clr_gen.sv
`timescale 1ns/1ps
// Builds the per-source clear mask from the various clear events.
module ivg_clr_gen #(
    parameter int NUM_SRC   = 13,
    parameter int NUM_SLOTS = 8,
    parameter int STAT      = 5,
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 rd_i,
    input  logic                 top_vld_i,
    input  logic [IW-1:0]        top_idx_i,
    input  logic [NUM_SLOTS-1:0] slot_rd_i,
    input  logic [NUM_SRC-1:0]   sw_clr_i,
    output logic [NUM_SRC-1:0]   clr_o
);

    logic [NUM_SRC-1:0] slot_mask;
    logic [NUM_SRC-1:0] rd_mask;

    // status bits are never touched by slot reads
    for (genvar g = 0; g < STAT; g++) begin : g_stat
        assign slot_mask[g] = 1'b0;
    end
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_mask[STAT+s] = slot_rd_i[s];
    end

    // a vector read only drops the winner when it is a status condition
    always_comb begin
        rd_mask = '0;
        if (rd_i && top_vld_i && (int'(top_idx_i) < STAT)) begin
            rd_mask[top_idx_i] = 1'b1;
        end
    end

    assign clr_o = sw_clr_i | slot_mask | rd_mask;

endmodule

// File: rtl/ivg_flag_next.sv
`timescale 1ns/1ps
// Per-flag next-state: a set pulse overrides every clear source.
module ivg_flag_next #(
    parameter int NUM_SRC = 13
) (
    input  logic [NUM_SRC-1:0] cur_i,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               clr_all_i,
    output logic [NUM_SRC-1:0] nxt_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        assign nxt_o[g] = set_i[g] | (cur_i[g] & ~clr_i[g] & ~clr_all_i);
    end

endmodule

// File: rtl/ivg_top.sv
`timescale 1ns/1ps
module ivg_top #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_SRC   = ivg_pkg::STAT_CNT + NUM_SLOTS,
    parameter int VEC_W     = $clog2(2 * NUM_SRC + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 vec_rd_i,
    input  logic                 vec_wr_i,
    input  logic [NUM_SRC-1:0]   src_en_i,
    input  logic [NUM_SRC-1:0]   src_set_i,
    input  logic [NUM_SRC-1:0]   src_clr_i,
    input  logic [NUM_SLOTS-1:0] slot_rd_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vector_o,
    output logic [NUM_SRC-1:0]   pend_o
);

    localparam int STAT = ivg_pkg::STAT_CNT;
    localparam int IW   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
        logic               irq;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] active;
    logic               top_vld;
    logic [IW-1:0]      top_idx;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] flags_nxt;

    assign active = st_q.flags & src_en_i;

    ivg_prio_pick #(.W(NUM_SRC)) u_pick (
        .req_i (active),
        .vld_o (top_vld),
        .idx_o (top_idx)
    );

    ivg_clr_gen #(
        .NUM_SRC   (NUM_SRC),
        .NUM_SLOTS (NUM_SLOTS),
        .STAT      (STAT)
    ) u_clr (
        .rd_i      (vec_rd_i),
        .top_vld_i (top_vld),
        .top_idx_i (top_idx),
        .slot_rd_i (slot_rd_i),
        .sw_clr_i  (src_clr_i),
        .clr_o     (clr_mask)
    );

    ivg_flag_next #(.NUM_SRC(NUM_SRC)) u_next (
        .cur_i     (st_q.flags),
        .set_i     (src_set_i),
        .clr_i     (clr_mask),
        .clr_all_i (vec_wr_i),
        .nxt_o     (flags_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = flags_nxt;
        st_d.irq   = |(flags_nxt & src_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // even jump-table offset: rank k maps to 2*(k+1)
    assign vector_o = top_vld ? (VEC_W'({top_idx, 1'b0}) + VEC_W'(2)) : '0;
    assign irq_o    = st_q.irq;
    assign pend_o   = st_q.flags;

endmodule

// File: rtl/ivg_chk.sv
`timescale 1ns/1ps
module ivg_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_SRC   = 13,
    parameter int VEC_W     = 5
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 vec_rd_i,
    input logic                 vec_wr_i,
    input logic [NUM_SRC-1:0]   src_en_i,
    input logic [NUM_SRC-1:0]   src_set_i,
    input logic [NUM_SRC-1:0]   src_clr_i,
    input logic [NUM_SLOTS-1:0] slot_rd_i,
    input logic                 irq_o,
    input logic [VEC_W-1:0]     vector_o,
    input logic [NUM_SRC-1:0]   pend_o
);

    localparam int STAT = ivg_pkg::STAT_CNT;
    localparam logic [VEC_W-1:0] FIRST_SLOT_VEC = VEC_W'(2 * (STAT + 1));

    assert_vec_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_o & src_en_i) == '0) |-> (vector_o == '0));

    assert_ovf_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o[0] && src_en_i[0]) |-> (vector_o == VEC_W'(2)));

    assert_rd_clr_stat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_rd_i && (vector_o == VEC_W'(2)) && !src_set_i[0]) |=> !pend_o[0]);

    assert_rd_keep_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_rd_i && !vec_wr_i && (vector_o >= FIRST_SLOT_VEC) && (src_set_i == '0)
         && (slot_rd_i == '0) && (src_clr_i == '0)) |=> $stable(pend_o));

    assert_wr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_wr_i && (src_set_i == '0)) |=> (pend_o == '0));

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_set_i != '0) |=> ((pend_o & $past(src_set_i)) == $past(src_set_i)));

    assert_irq_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == |(pend_o & $past(src_en_i))));

endmodule

bind ivg_top ivg_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_SRC   (NUM_SRC),
    .VEC_W     (VEC_W)
) u_ivg_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vec_rd_i  (vec_rd_i),
    .vec_wr_i  (vec_wr_i),
    .src_en_i  (src_en_i),
    .src_set_i (src_set_i),
    .src_clr_i (src_clr_i),
    .slot_rd_i (slot_rd_i),
    .irq_o     (irq_o),
    .vector_o  (vector_o),
    .pend_o    (pend_o)
);

// File: tb/test_ivg_top.sv
`timescale 1ns/1ps
module test_ivg_top;

    localparam int NSL  = 4;
    localparam int STAT = 5;
    localparam int N    = STAT + NSL;
    localparam int VW   = $clog2(2 * N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [N-1:0]  en = '0, set = '0, clr = '0;
    logic [NSL-1:0] srd = '0;
    logic          irq;
    logic [VW-1:0] vec;
    logic [N-1:0]  pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [N-1:0]  pend;
        logic          irq;
        logic [VW-1:0] vec;
        string         tag;
    } exp_t;

    exp_t sb[$];
    logic [N-1:0] mflags = '0;

    always #4 clk = ~clk;   // 125 MHz

    ivg_top #(.NUM_SLOTS(NSL)) i_ivg_top (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .vec_rd_i  (rd),
        .vec_wr_i  (wr),
        .src_en_i  (en),
        .src_set_i (set),
        .src_clr_i (clr),
        .slot_rd_i (srd),
        .irq_o     (irq),
        .vector_o  (vec),
        .pend_o    (pend)
    );

    // R1/R2: value from rank of first enabled pending source
    function automatic logic [VW-1:0] vec_of(logic [N-1:0] f, logic [N-1:0] e);
        for (int k = 0; k < N; k++) begin
            if (f[k] && e[k]) return VW'(2 * (k + 1));
        end
        return '0;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outcome
    task automatic cyc(input logic r, input logic w, input logic [N-1:0] e,
                       input logic [N-1:0] s, input logic [NSL-1:0] sr,
                       input logic [N-1:0] c, input string tag);
        logic [N-1:0] nf;
        exp_t it;
        @(negedge clk);
        rd = r; wr = w; en = e; set = s; srd = sr; clr = c;
        nf = mflags;
        if (w) begin
            nf = '0;                                   // R8
        end else begin
            if (r) begin
                for (int k = 0; k < N; k++) begin
                    if (mflags[k] && e[k]) begin
                        if (k < STAT) nf[k] = 1'b0;    // R4, R5
                        break;
                    end
                end
            end
            for (int q = 0; q < NSL; q++) if (sr[q]) nf[STAT+q] = 1'b0; // R6
            nf = nf & ~c;                              // R7
        end
        nf = nf | s;                                   // R9
        mflags = nf;
        it.pend = nf;
        it.irq  = |(nf & e);                           // R10
        it.vec  = vec_of(nf, e);
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares design outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (pend !== it.pend || irq !== it.irq || vec !== it.vec) begin
                    errors++;
                    $display("FAIL %s: pend=%b irq=%b vec=%0d expected pend=%b irq=%b vec=%0d",
                             it.tag, pend, irq, vec, it.pend, it.irq, it.vec);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [N-1:0] ALL = '1;
    localparam logic [N-1:0] OVF = N'(1) << 0;
    localparam logic [N-1:0] TOV = N'(1) << 1;
    localparam logic [N-1:0] WHI = N'(1) << 2;
    localparam logic [N-1:0] WLO = N'(1) << 3;
    localparam logic [N-1:0] WIN = N'(1) << 4;
    localparam logic [N-1:0] SL0 = N'(1) << 5;
    localparam logic [N-1:0] SL1 = N'(1) << 6;
    localparam logic [N-1:0] SL2 = N'(1) << 7;
    localparam logic [N-1:0] SL3 = N'(1) << 8;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;   // R11 reset state
        if (pend !== '0 || irq !== 1'b0 || vec !== '0) begin
            errors++;
            $display("FAIL R11: pend=%b irq=%b vec=%0d expected pend=0 irq=0 vec=0", pend, irq, vec);
        end

        cyc(0, 0, ALL, '0, '0, '0, "R1 idle");
        cyc(0, 0, ALL, OVF | SL3, '0, '0, "R2 ovf over slot3");
        cyc(1, 0, ALL, '0, '0, '0, "R4 read drops ovf, R10 irq held");
        cyc(1, 0, ALL, '0, '0, '0, "R5 read keeps slot3");
        cyc(0, 0, ALL, '0, 4'b1000, '0, "R6 slot3 read, R1 zero");
        cyc(0, 0, ALL, TOV | WLO, '0, '0, "R2 tov over wlo");
        cyc(0, 0, ALL & ~TOV, '0, '0, '0, "R3 tov disabled");
        cyc(0, 0, SL0 | SL1 | SL2 | SL3, '0, '0, '0, "R3 all status masked");
        cyc(1, 0, SL0 | SL1 | SL2 | SL3, '0, '0, '0, "R3 masked read clears none");
        cyc(0, 0, ALL, '0, '0, '0, "R3 flags kept");
        cyc(0, 0, ALL, '0, '0, TOV, "R7 sw clear tov");
        cyc(0, 0, ALL, SL0, 4'b0001, SL0, "R9 set beats clear");
        cyc(0, 0, ALL, '0, '0, '0, "R9 slot0 held");
        cyc(0, 1, ALL, '0, '0, '0, "R8 write clears all");
        cyc(0, 0, ALL, WHI | WIN | SL1, '0, '0, "R2 whi top");
        cyc(1, 0, ALL, '0, '0, '0, "R4 read drops whi");
        cyc(1, 0, ALL, '0, '0, '0, "R4 read drops win");
        cyc(1, 0, ALL, '0, '0, '0, "R5 read keeps slot1");
        cyc(1, 0, ALL, OVF, '0, '0, "R9 set beats read clear");
        cyc(0, 1, ALL, SL2, '0, '0, "R9 set beats write");
        cyc(0, 0, ALL, '0, 4'b0100, '0, "R6 slot2 read");
        cyc(0, 0, ALL, SL0 | SL3, '0, '0, "R2 slot0 over slot3");
        cyc(0, 0, ALL, '0, '0, SL0, "R7 clear slot0");
        cyc(0, 0, '0, '0, '0, '0, "R10 irq drops when disabled");

        @(negedge clk);
        rd = 0; wr = 0; set = '0; clr = '0; srd = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule